// File: doc/BRIEF.md
# Transmit Header-Insertion Gearbox

This block packs 64-bit block payloads into a gap-free 32-bit-per-cycle stream for a serializer. Each payload arrives on a 32-bit upstream bus as two halves, low half first. The sync header (2 bits in 66-bit framing, 3 bits in 67-bit framing) is sampled together with the first half. The block places the header ahead of the payload so that the serial wire carries header bit 0 first, then the header's other bits, then payload bit 0 onward.

A framed block is longer than its payload, so the upstream side cannot be accepted on every cycle. A fixed cyclic pause scheduler drops `in_ready` on set phases of a repeating frame. In 66-bit framing the frame is 33 cycles with one pause, which gives 32 half-blocks per 33 output words. In 67-bit framing the frame is 67 cycles with three pauses, which gives 64 half-blocks per 67 output words. Accepted bits are appended to a residue register behind a bit-count pointer. The oldest 32 bits leave from the bottom of that register whenever at least 32 are held.

The framing mode is captured on the first clock after reset release. It stays fixed until the next reset.

Top module: `tx_hdr_gearbox`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1. Release restarts the pause frame at phase 0 with an empty residue.
- R2: When upstream presents `in_valid` high on every cycle that `in_ready` is high, `out_valid` is high on every cycle from the second cycle after reset release onward.
- R3: With `mode_67` = 0 (66-bit framing), `in_ready` is low only on cycle index n where n mod 33 = 32. Index 0 is the first cycle after release.
- R4: With `mode_67` = 1 (67-bit framing), `in_ready` is low only on cycle index n where n mod 67 is 22, 44 or 66.
- R5: In 66-bit framing, each block is sent as `in_hdr[1:0]` followed by the 64 payload bits. `out_data[0]` is the earliest bit on the wire, and the payload follows bit 0 first.
- R6: In 67-bit framing, each block is sent as `in_hdr[2:0]` followed by the 64 payload bits, with the same bit order as R5.
- R7: `in_hdr` is sampled only with the first (low) half of a block. Its value during a second-half beat has no effect on `out_data`.
- R8: A change of `mode_67` after reset release changes neither the pause pattern nor the header width until the next reset.
- R9: A beat is taken only when `in_valid` and `in_ready` are both high. If `in_valid` is low on a ready cycle, the same half is still expected next. `out_valid` drops on any cycle where fewer than 32 bits are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_67 | input | 1 | 0 = 66-bit framing, 1 = 67-bit framing (captured after reset) |
| in_valid | input | 1 | Upstream half-block present |
| in_ready | output | 1 | Gearbox accepts a half-block this cycle |
| in_data | input | 32 | Payload half, low half first |
| in_hdr | input | 3 | Sync header, used only with the first half |
| out_data | output | 32 | Serial-order word, bit 0 sent first |
| out_valid | output | 1 | `out_data` carries 32 valid bits |

## Verification
The bench models the wire as a queue of bits built from every accepted beat and compares each output word against it. This catches a header placed after the payload, a wrong header width, a half sent in the wrong order, or a stray second-half header leaking onto the wire, each of which shows as a word that differs from the queue. Pause positions are checked on every cycle in both framings. A scheduler with a wrong period or a wrong pause phase either starves the output, so `out_valid` falls, or shows `in_ready` low on an unexpected cycle. The directed tests withhold one beat, flip the mode after release, and reset in mid-stream. These catch a half pointer that advances without a handshake, a mode that is not latched, and a residue or frame counter that survives reset.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  localparam int LANE_W  = 32;  // upstream and downstream word width
  localparam int PAY_W   = 64;  // payload bits per block
  localparam int HDR_MAX = 3;   // widest sync header
  localparam int BEAT_W  = LANE_W + HDR_MAX;

  typedef enum logic {
    FRAME66 = 1'b0,
    FRAME67 = 1'b1
  } frame_e;
endpackage

// File: rtl/gbx_sched.sv
module gbx_sched
  import gbx_pkg::*;
#(
  parameter int PAYLOAD_W = PAY_W
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mode_in,
  input  logic   acc,
  output frame_e mode_eff,
  output logic   in_ready,
  output logic   first_half
);
  localparam int P66 = (PAYLOAD_W + 2) / 2;   // 33-cycle frame
  localparam int P67 = PAYLOAD_W + 3;         // 67-cycle frame
  localparam int S67 = P67 / 3;               // pause spacing in 67-bit framing
  localparam int PH_W = $clog2(P67);
  localparam logic [PH_W-1:0] P66_LAST = PH_W'(P66 - 1);
  localparam logic [PH_W-1:0] P67_LAST = PH_W'(P67 - 1);
  localparam logic [PH_W-1:0] S67_C    = PH_W'(S67);

  logic            armed_q, armed_d;
  frame_e          mode_q, mode_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            half_q, half_d;
  logic            last, stall;

  always_comb begin
    mode_eff = armed_q ? mode_q : frame_e'(mode_in);
    armed_d  = 1'b1;
    mode_d   = armed_q ? mode_q : frame_e'(mode_in);
    last     = (mode_eff == FRAME67) ? (phase_q == P67_LAST) : (phase_q == P66_LAST);
    if (mode_eff == FRAME67)
      stall = (phase_q != '0) && ((phase_q % S67_C) == '0);
    else
      stall = last;
    phase_d    = last ? '0 : phase_q + 1'b1;
    half_d     = acc ? ~half_q : half_q;
    in_ready   = ~stall;
    first_half = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= FRAME66;
      phase_q <= '0;
      half_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      mode_q  <= mode_d;
      phase_q <= phase_d;
      half_q  <= half_d;
    end
  end

  // R3 R4
  stall_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R9
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(half_q));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(mode_eff));
endmodule

// File: rtl/gbx_beat_fmt.sv
module gbx_beat_fmt
  import gbx_pkg::*;
(
  input  frame_e              mode,
  input  logic                first,
  input  logic [LANE_W-1:0]   data,
  input  logic [HDR_MAX-1:0]  hdr,
  output logic [BEAT_W-1:0]   beat,
  output logic [5:0]          len
);
  always_comb begin
    if (first && mode == FRAME67) begin
      beat = {data, hdr};
      len  = 6'(LANE_W + 3);
    end else if (first) begin
      beat = {1'b0, data, hdr[1:0]};
      len  = 6'(LANE_W + 2);
    end else begin
      beat = {{HDR_MAX{1'b0}}, data};
      len  = 6'(LANE_W);
    end
  end
endmodule

// File: rtl/gbx_residue.sv
module gbx_residue
  import gbx_pkg::*;
#(
  parameter int RES_W = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [BEAT_W-1:0] beat,
  input  logic [5:0]        len,
  output logic [LANE_W-1:0] out_data,
  output logic              out_valid
);
  localparam int CW = $clog2(RES_W + 1);
  localparam logic [CW-1:0] LANE_C = CW'(LANE_W);
  localparam logic [CW-1:0] RES_C  = CW'(RES_W);

  logic [RES_W-1:0] res_q, res_d, shifted, keep, ins;
  logic [CW-1:0]    cnt_q, cnt_d, base;
  logic             pop;

  always_comb begin
    pop     = cnt_q >= LANE_C;
    base    = pop ? cnt_q - LANE_C : cnt_q;
    shifted = pop ? (res_q >> LANE_W) : res_q;
    keep    = shifted & ({RES_W{1'b1}} >> (RES_C - base));
    ins     = {{(RES_W-BEAT_W){1'b0}}, beat} << base;
    res_d   = acc ? (keep | ins) : keep;
    cnt_d   = base + (acc ? CW'(len) : '0);
    out_data  = res_q[LANE_W-1:0];
    out_valid = pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cnt_q <= '0;
    end else begin
      res_q <= res_d;
      cnt_q <= cnt_d;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RES_C);

  // R2
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !acc) |=> (cnt_q == $past(cnt_q) - LANE_C));
endmodule

// File: rtl/tx_hdr_gearbox.sv
module tx_hdr_gearbox
  import gbx_pkg::*;
#(
  parameter int RES_W = 96
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_67,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic [2:0]  in_hdr,
  output logic [31:0] out_data,
  output logic        out_valid
);
  frame_e            mode_eff;
  logic              first_half, acc;
  logic [BEAT_W-1:0] beat;
  logic [5:0]        len;

  assign acc = in_valid & in_ready;

  gbx_sched #(.PAYLOAD_W(PAY_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_67), .acc(acc),
    .mode_eff(mode_eff), .in_ready(in_ready), .first_half(first_half)
  );

  gbx_beat_fmt u_fmt (
    .mode(mode_eff), .first(first_half), .data(in_data), .hdr(in_hdr),
    .beat(beat), .len(len)
  );

  gbx_residue #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .acc(acc), .beat(beat), .len(len),
    .out_data(out_data), .out_valid(out_valid)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/tb_tx_hdr_gearbox.sv
`timescale 1ns/1ps
module tb_tx_hdr_gearbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_67 = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [2:0]  in_hdr = '0;
  logic [31:0] out_data;
  logic        out_valid;

  always #10 clk = ~clk;  // 50 MHz

  tx_hdr_gearbox dut (
    .clk(clk), .rst_n(rst_n), .mode_67(mode_67), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_hdr(in_hdr),
    .out_data(out_data), .out_valid(out_valid)
  );

  int applied = 0;
  int misses  = 0;
  bit done    = 0;
  bit exp_q[$];
  int cyc, blk, inval;
  bit half, mode_lat;

  // columns: mode, cycles, cycle index with in_valid withheld (-1 none)
  localparam int VEC [4][3] = '{'{0, 70, -1}, '{1, 140, -1}, '{0, 40, 12}, '{1, 80, 31}};

  function automatic logic [63:0] payload(int k);
    return {32'(k) * 32'h9E3779B9, 32'(k) ^ 32'hA5C3_0F71};
  endfunction

  function automatic logic [2:0] hdr_of(int k);
    return (k % 2 == 0) ? 3'b101 : 3'b010;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    applied++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset(bit m);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    mode_67  = m;
    repeat (2) @(negedge clk);
    // R1
    check(!out_valid && in_ready, "R1", {30'b0, out_valid, in_ready}, 32'h1);
    rst_n = 1'b1;
    exp_q.delete();
    cyc = 0; blk = 0; half = 0; inval = 0; mode_lat = m;
  endtask

  task automatic step(int drop_at);
    logic [31:0] e;
    logic [63:0] p;
    int ph;
    bit stall, v;
    if (out_valid) begin
      if (exp_q.size() < 32) check(0, "R9", out_data, 32'h0);
      else begin
        for (int b = 0; b < 32; b++) e[b] = exp_q.pop_front();
        check(out_data == e, mode_lat ? "R6" : "R5", out_data, e);
      end
    end else begin
      inval++;
      if (cyc >= 1 && drop_at < 0) check(0, "R2", 32'(out_valid), 32'h1);
    end
    ph = mode_lat ? cyc % 67 : cyc % 33;
    stall = mode_lat ? (ph == 22 || ph == 44 || ph == 66) : (ph == 32);
    check(in_ready == !stall, mode_lat ? "R4" : "R3", 32'(in_ready), 32'(!stall));
    v = (cyc != drop_at);
    p = payload(blk);
    in_valid = v;
    in_data  = half ? p[63:32] : p[31:0];
    in_hdr   = half ? ~hdr_of(blk) : hdr_of(blk);  // R7: junk on second half
    if (v && in_ready) begin
      if (!half) begin
        for (int b = 0; b < (mode_lat ? 3 : 2); b++) exp_q.push_back(hdr_of(blk)[b]);
        for (int b = 0; b < 32; b++) exp_q.push_back(p[b]);
      end else begin
        for (int b = 32; b < 64; b++) exp_q.push_back(p[b]);
        blk++;
      end
      half = ~half;
    end
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      do_reset(VEC[i][0] != 0);
      for (int c = 0; c < VEC[i][1]; c++) step(VEC[i][2]);
      // R9: one withheld beat leaves the residue short at least once
      if (VEC[i][2] >= 0) check(inval > 1, "R9", 32'(inval), 32'h2);
    end
    // R8: mode flipped after release keeps 66-bit framing
    do_reset(1'b0);
    for (int c = 0; c < 5; c++) step(-1);
    mode_67 = 1'b1;
    for (int c = 0; c < 70; c++) step(-1);
    check(mode_lat == 0, "R8", 32'(mode_lat), 32'h0);
    // R1: reset in mid-stream, then 67-bit framing from a clean start
    do_reset(1'b1);
    for (int c = 0; c < 70; c++) step(-1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end
endmodule